// File: doc/BRIEF.md
# Daisy-Chain Register Message Router

This block sits on one hop of a chain of devices that share a serial register link. Upstream logic delivers decoded frame payload bytes, each frame bracketed by a start strobe and an end strobe. The router buffers the whole frame and checks that it is exactly eleven bytes long and that all eleven bytes add up to zero modulo 256. It then reads the hop count held in the low nibble of the first byte.

A hop count of one means the frame targets this device. The router performs one access on a simple local register bus. For a non-posted request, it returns an eleven-byte reply on a dedicated reply port. The reply repeats the header and the register address, carries read data (or the write data, for writes), and ends with a status byte and a fresh checksum. A hop count of two or more sends the frame out on the downstream port with the count lowered by one and the checksum rebuilt. A hop count of zero, a bad length and a bad sum all cause the frame to be discarded.

Only one message is ever in flight, so the block has no flow control. Input that arrives while a message is being handled is discarded.

Top module: `chain_msg_router`

## Requirements
- R1: A frame is accepted only when exactly 11 payload bytes arrive between the start and end strobes and their 8-bit sum is 0. Any other frame causes no bus access and no output on either port.
- R2: The header (byte 0) holds the hop count in bits [3:0], write-not-read in bit 4 (1 = write) and posted in bit 5. Bits 7:6 are carried unchanged.
- R3: An accepted frame with hop count 1 raises bus_req for one cycle. bus_addr is taken from bytes 1..4 and bus_wdata from bytes 5..8, both most significant byte first, and bus_we equals header bit 4.
- R4: An accepted frame with hop count 2..15 leaves on the downstream port. Its hop count is one lower and its header bits 7:4 are unchanged. Bytes 1..9 are unchanged, and byte 10 is recomputed so that the 11-byte sum is 0.
- R5: An accepted frame with hop count 0 is discarded: no bus access and no output.
- R6: A local non-posted request produces one reply frame on the reply port. Bytes 0..4 repeat the request. Bytes 5..8 carry bus_rdata for a read or the request's write data for a write. Byte 9 is 0x01 if bus_err was high with bus_rdy, otherwise 0x00. Byte 10 makes the 11-byte sum 0.
- R7: A local posted request (bit 5 set) performs the bus access but produces no reply.
- R8: Every output frame is one start strobe, then 11 consecutive byte-valid cycles, then one end strobe. The downstream and reply ports are never active in the same cycle.
- R9: From the cycle after an accepted frame's end strobe until its handling is complete, start, byte and end strobes on the input are discarded. A frame sent in that window has no effect.
- R10: bus_req lasts one cycle, and no new bus_req is raised until bus_rdy has answered the previous one. bus_rdy is sampled no earlier than the cycle after bus_req.
- R11: After reset, bus_req, all strobes of both output ports and the output bytes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe from the link decoder |
| rx_vld | input | 1 | Payload byte valid |
| rx_byte | input | 8 | Payload byte |
| rx_eof | input | 1 | End-of-frame strobe |
| fwd_sof | output | 1 | Downstream start-of-frame strobe |
| fwd_vld | output | 1 | Downstream byte valid |
| fwd_byte | output | 8 | Downstream byte |
| fwd_eof | output | 1 | Downstream end-of-frame strobe |
| rsp_sof | output | 1 | Reply start-of-frame strobe |
| rsp_vld | output | 1 | Reply byte valid |
| rsp_byte | output | 8 | Reply byte |
| rsp_eof | output | 1 | Reply end-of-frame strobe |
| bus_req | output | 1 | Single-cycle local bus request |
| bus_we | output | 1 | Local bus write enable |
| bus_addr | output | 32 | Local bus register address |
| bus_wdata | output | 32 | Local bus write data |
| bus_rdy | input | 1 | Local bus completion strobe |
| bus_rdata | input | 32 | Local bus read data, valid with bus_rdy |
| bus_err | input | 1 | Local bus error flag, valid with bus_rdy |

## Verification
The bus assertions rely on the local bus raising bus_rdy once per request, only after bus_req and before any further request. The bench's bus model answers each request exactly once, after a latency of one to eight cycles. The framing checks rely on upstream start, byte and end strobes never being raised together. The bench drives them from a single task that keeps them one-hot, and it sends a second frame into the busy window on purpose to exercise the discard path.

// File: rtl/chain_msg_pkg.sv
package chain_msg_pkg;
   // Header field positions
   localparam int HOP_LSB   = 0;
   localparam int HOP_W     = 4;
   localparam int WR_BIT    = 4;
   localparam int POST_BIT  = 5;
   // Reply status codes
   localparam logic [7:0] STAT_OK  = 8'h00;
   localparam logic [7:0] STAT_ERR = 8'h01;

   typedef enum logic [1:0] {
      RT_IDLE,
      RT_REQ,
      RT_WAIT,
      RT_SEND
   } route_st_e;
endpackage

// File: rtl/chain_msg_rx.sv
module chain_msg_rx #(
   parameter int FRAME_BYTES = 11
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         in_sof,
   input  logic                         in_vld,
   input  logic [7:0]                   in_byte,
   input  logic                         in_eof,
   output logic [FRAME_BYTES-1:0][7:0]  frame_q,
   output logic                         done_q,
   output logic                         good_q
);
   localparam int CNT_W = $clog2(FRAME_BYTES + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BYTES);

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sum_q    <= '0;
         done_q   <= 1'b0;
         good_q   <= 1'b0;
         frame_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!en) begin
            active_q <= 1'b0;
         end else if (in_sof) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            sum_q    <= '0;
         end else if (active_q && in_vld) begin
            if (cnt_q < CNT_FULL) frame_q[cnt_q] <= in_byte;
            if (cnt_q <= CNT_FULL) cnt_q <= cnt_q + 1'b1;
            sum_q <= sum_q + in_byte;
         end else if (active_q && in_eof) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            good_q   <= (cnt_q == CNT_FULL) && (sum_q == 8'd0);
         end
      end
   end
endmodule

// File: rtl/chain_msg_tx.sv
module chain_msg_tx #(
   parameter int FRAME_BYTES = 11
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [FRAME_BYTES-2:0][7:0]  body,
   output logic                         o_sof,
   output logic                         o_vld,
   output logic [7:0]                   o_byte,
   output logic                         o_eof
);
   localparam int POS_W = $clog2(FRAME_BYTES + 2);
   localparam logic [POS_W-1:0] POS_SUM = POS_W'(FRAME_BYTES);
   localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_BYTES + 1);

   logic                        busy_q;
   logic [POS_W-1:0]            pos_q;
   logic [7:0]                  acc_q;
   logic [FRAME_BYTES-2:0][7:0] body_q;
   logic [POS_W-1:0]            idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pos_q  <= '0;
         acc_q  <= '0;
         body_q <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         pos_q  <= '0;
         acc_q  <= '0;
         body_q <= body;
      end else if (busy_q) begin
         pos_q <= pos_q + 1'b1;
         if (o_vld) acc_q <= acc_q + o_byte;
         if (pos_q == POS_END) busy_q <= 1'b0;
      end
   end

   always_comb begin
      idx    = pos_q - 1'b1;
      o_sof  = busy_q && (pos_q == '0);
      o_vld  = busy_q && (pos_q != '0) && (pos_q <= POS_SUM);
      o_eof  = busy_q && (pos_q == POS_END);
      o_byte = 8'd0;
      if (o_vld) begin
         if (pos_q == POS_SUM) o_byte = 8'd0 - acc_q;
         else                  o_byte = body_q[idx];
      end
   end
endmodule

// File: rtl/chain_msg_router.sv
module chain_msg_router
   import chain_msg_pkg::*;
#(
   parameter int ADDR_BYTES  = 4,
   parameter int DATA_BYTES  = 4,
   parameter bit WR_RSP_ECHO = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_sof,
   input  logic                    rx_vld,
   input  logic [7:0]              rx_byte,
   input  logic                    rx_eof,
   output logic                    fwd_sof,
   output logic                    fwd_vld,
   output logic [7:0]              fwd_byte,
   output logic                    fwd_eof,
   output logic                    rsp_sof,
   output logic                    rsp_vld,
   output logic [7:0]              rsp_byte,
   output logic                    rsp_eof,
   output logic                    bus_req,
   output logic                    bus_we,
   output logic [8*ADDR_BYTES-1:0] bus_addr,
   output logic [8*DATA_BYTES-1:0] bus_wdata,
   input  logic                    bus_rdy,
   input  logic [8*DATA_BYTES-1:0] bus_rdata,
   input  logic                    bus_err
);
   localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES + 3;
   localparam int ADDR_W      = 8 * ADDR_BYTES;
   localparam int DATA_W      = 8 * DATA_BYTES;
   localparam int DATA_OFS    = 1 + ADDR_BYTES;
   localparam int STAT_OFS    = DATA_OFS + DATA_BYTES;

   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("chain_msg_router: ADDR_BYTES must be 1..4");
   end
   if (DATA_BYTES < 1 || DATA_BYTES > 4) begin : g_bad_data
      $error("chain_msg_router: DATA_BYTES must be 1..4");
   end

   route_st_e                    st_q;
   logic                         sel_rsp_q;
   logic [FRAME_BYTES-1:0][7:0]  rx_frame;
   logic                         rx_done, rx_good;
   logic [7:0]                   hdr;
   logic [HOP_W-1:0]             hop;
   logic                         is_wr, is_post;
   logic [ADDR_W-1:0]            req_addr;
   logic [DATA_W-1:0]            req_wdata, rsp_data;
   logic                         take, load_fwd, load_rsp;
   logic [FRAME_BYTES-2:0][7:0]  tx_body;
   logic                         t_sof, t_vld, t_eof;
   logic [7:0]                   t_byte;

   chain_msg_rx #(.FRAME_BYTES(FRAME_BYTES)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (st_q == RT_IDLE),
      .in_sof  (rx_sof),
      .in_vld  (rx_vld),
      .in_byte (rx_byte),
      .in_eof  (rx_eof),
      .frame_q (rx_frame),
      .done_q  (rx_done),
      .good_q  (rx_good)
   );

   assign hdr     = rx_frame[0];
   assign hop     = hdr[HOP_LSB +: HOP_W];
   assign is_wr   = hdr[WR_BIT];
   assign is_post = hdr[POST_BIT];

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
      assign req_addr[8*(ADDR_BYTES-1-i) +: 8] = rx_frame[1 + i];
   end
   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_wdata
      assign req_wdata[8*(DATA_BYTES-1-i) +: 8] = rx_frame[DATA_OFS + i];
   end

   if (WR_RSP_ECHO) begin : g_echo_wr
      assign rsp_data = is_wr ? req_wdata : bus_rdata;
   end else begin : g_raw_rd
      assign rsp_data = bus_rdata;
   end

   assign take     = (st_q == RT_IDLE) && rx_done && rx_good;
   assign load_fwd = take && (hop > HOP_W'(1));
   assign load_rsp = (st_q == RT_WAIT) && bus_rdy && !is_post;

   always_comb begin
      for (int b = 0; b < FRAME_BYTES - 1; b++) tx_body[b] = rx_frame[b];
      if (load_rsp) begin
         for (int b = 0; b < DATA_BYTES; b++)
            tx_body[DATA_OFS + b] = rsp_data[8*(DATA_BYTES-1-b) +: 8];
         tx_body[STAT_OFS] = bus_err ? STAT_ERR : STAT_OK;
      end else begin
         tx_body[0][HOP_LSB +: HOP_W] = hop - 1'b1;
      end
   end

   chain_msg_tx #(.FRAME_BYTES(FRAME_BYTES)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_fwd || load_rsp),
      .body   (tx_body),
      .o_sof  (t_sof),
      .o_vld  (t_vld),
      .o_byte (t_byte),
      .o_eof  (t_eof)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RT_IDLE;
         sel_rsp_q <= 1'b0;
      end else begin
         case (st_q)
            RT_IDLE: begin
               if (take && hop == HOP_W'(1)) st_q <= RT_REQ;
               else if (load_fwd) begin
                  st_q      <= RT_SEND;
                  sel_rsp_q <= 1'b0;
               end
            end
            RT_REQ:  st_q <= RT_WAIT;
            RT_WAIT: begin
               if (bus_rdy) begin
                  if (is_post) st_q <= RT_IDLE;
                  else begin
                     st_q      <= RT_SEND;
                     sel_rsp_q <= 1'b1;
                  end
               end
            end
            default: if (t_eof) st_q <= RT_IDLE;
         endcase
      end
   end

   assign bus_req   = (st_q == RT_REQ);
   assign bus_we    = is_wr;
   assign bus_addr  = req_addr;
   assign bus_wdata = req_wdata;

   assign fwd_sof  = t_sof && !sel_rsp_q;
   assign fwd_vld  = t_vld && !sel_rsp_q;
   assign fwd_eof  = t_eof && !sel_rsp_q;
   assign fwd_byte = sel_rsp_q ? 8'd0 : t_byte;
   assign rsp_sof  = t_sof && sel_rsp_q;
   assign rsp_vld  = t_vld && sel_rsp_q;
   assign rsp_eof  = t_eof && sel_rsp_q;
   assign rsp_byte = sel_rsp_q ? t_byte : 8'd0;
endmodule

// File: rtl/chain_msg_router_chk.sv
module chain_msg_router_chk #(
   parameter int FRAME_BYTES = 11
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_req,
   input logic       bus_rdy,
   input logic       fwd_sof,
   input logic       fwd_vld,
   input logic [7:0] fwd_byte,
   input logic       fwd_eof,
   input logic       rsp_sof,
   input logic       rsp_vld,
   input logic [7:0] rsp_byte,
   input logic       rsp_eof
);
   localparam int CW = $clog2(FRAME_BYTES + 2);
   localparam logic [CW-1:0] CMAX = CW'(FRAME_BYTES + 1);

   logic          pend_q;
   logic [7:0]    fsum_q, rsum_q;
   logic [CW-1:0] fcnt_q, rcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         fsum_q <= '0;
         rsum_q <= '0;
         fcnt_q <= '0;
         rcnt_q <= '0;
      end else begin
         if (bus_req)      pend_q <= 1'b1;
         else if (bus_rdy) pend_q <= 1'b0;
         if (fwd_sof) begin
            fsum_q <= '0;
            fcnt_q <= '0;
         end else if (fwd_vld) begin
            fsum_q <= fsum_q + fwd_byte;
            if (fcnt_q != CMAX) fcnt_q <= fcnt_q + 1'b1;
         end
         if (rsp_sof) begin
            rsum_q <= '0;
            rcnt_q <= '0;
         end else if (rsp_vld) begin
            rsum_q <= rsum_q + rsp_byte;
            if (rcnt_q != CMAX) rcnt_q <= rcnt_q + 1'b1;
         end
      end
   end

   assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);
   assert_one_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !bus_req);
   assert_ports_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !((fwd_sof || fwd_vld || fwd_eof) && (rsp_sof || rsp_vld || rsp_eof)));
   assert_fwd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_sof, fwd_vld, fwd_eof}));
   assert_rsp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_sof, rsp_vld, rsp_eof}));
   assert_fwd_sof_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sof |=> fwd_vld);
   assert_rsp_sof_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sof |=> rsp_vld);
   assert_fwd_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_eof |-> fcnt_q == CW'(FRAME_BYTES));
   assert_rsp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_eof |-> rcnt_q == CW'(FRAME_BYTES));
   assert_fwd_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_eof |-> fsum_q == 8'd0);
   assert_rsp_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_eof |-> rsum_q == 8'd0);
endmodule

bind chain_msg_router chain_msg_router_chk #(.FRAME_BYTES(FRAME_BYTES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_rdy  (bus_rdy),
   .fwd_sof  (fwd_sof),
   .fwd_vld  (fwd_vld),
   .fwd_byte (fwd_byte),
   .fwd_eof  (fwd_eof),
   .rsp_sof  (rsp_sof),
   .rsp_vld  (rsp_vld),
   .rsp_byte (rsp_byte),
   .rsp_eof  (rsp_eof)
);

// File: tb/tb_chain_msg_router.sv
`timescale 1ns/1ps
module tb_chain_msg_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_sof = 1'b0, rx_vld = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_byte = 8'd0;
   logic        fwd_sof, fwd_vld, fwd_eof, rsp_sof, rsp_vld, rsp_eof;
   logic [7:0]  fwd_byte, rsp_byte;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_rdy = 1'b0;
   logic [31:0] bus_rdata = 32'd0;
   logic        bus_err = 1'b0;

   int checks = 0, failures = 0;
   int bus_lat = 1;
   logic [7:0]  fr [0:15];
   logic [7:0]  fcap [0:15];
   logic [7:0]  rcap [0:15];
   int fcnt = 0, rcnt = 0, fframes = 0, rframes = 0, nreq = 0;
   logic [31:0] c_addr, c_wdata;
   logic        c_we;

   always #2 clk = ~clk;

   chain_msg_router dut (.*);

   function automatic logic [31:0] mdl_rdata(input logic [31:0] a);
      return (a * 32'd2654435761) ^ 32'h0F0F_3C3C;
   endfunction
   function automatic logic mdl_err(input logic [31:0] a);
      return a[3:0] == 4'hF;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(negedge clk) begin
      if (fwd_sof) fcnt = 0;
      if (fwd_vld) begin if (fcnt < 16) fcap[fcnt] = fwd_byte; fcnt++; end
      if (fwd_eof) fframes++;
      if (rsp_sof) rcnt = 0;
      if (rsp_vld) begin if (rcnt < 16) rcap[rcnt] = rsp_byte; rcnt++; end
      if (rsp_eof) rframes++;
      if (bus_req) begin nreq++; c_addr = bus_addr; c_wdata = bus_wdata; c_we = bus_we; end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (bus_req) begin
            repeat (bus_lat) @(posedge clk);
            #1;
            bus_rdy   = 1'b1;
            bus_rdata = mdl_rdata(bus_addr);
            bus_err   = mdl_err(bus_addr);
            @(posedge clk); #1;
            bus_rdy = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic build(input logic [7:0] hdr, input logic [31:0] a,
                        input logic [31:0] d, input logic [7:0] foot);
      logic [7:0] s = 8'd0;
      fr[0] = hdr;
      for (int i = 0; i < 4; i++) fr[1+i] = a[8*(3-i) +: 8];
      for (int i = 0; i < 4; i++) fr[5+i] = d[8*(3-i) +: 8];
      fr[9] = foot;
      for (int i = 0; i < 10; i++) s = s + fr[i];
      fr[10] = 8'd0 - s;
   endtask

   task automatic send(input int n);
      @(posedge clk); #1; rx_sof = 1'b1;
      @(posedge clk); #1; rx_sof = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_vld = 1'b1; rx_byte = fr[i];
         @(posedge clk); #1;
      end
      rx_vld = 1'b0; rx_byte = 8'd0; rx_eof = 1'b1;
      @(posedge clk); #1; rx_eof = 1'b0;
   endtask

   task automatic clear_caps();
      fframes = 0; rframes = 0; nreq = 0; fcnt = 0; rcnt = 0;
   endtask

   task automatic expect_silent(input string req);
      check(nreq == 0, req, 64'(nreq), 64'd0);
      check(fframes == 0 && rframes == 0, req, 64'(fframes + rframes), 64'd0);
   endtask

   // Full expectation for one well-formed frame (R2..R8)
   task automatic run_case(input logic [7:0] hdr, input logic [31:0] a,
                           input logic [31:0] d, input int lat);
      logic [3:0]  hop = hdr[3:0];
      logic [7:0]  e [0:10];
      logic [7:0]  s = 8'd0;
      logic [31:0] rd;
      clear_caps();
      bus_lat = lat;
      build(hdr, a, d, 8'h5A);
      send(11);
      repeat (40) @(posedge clk); #1;
      if (hop == 4'd0) begin
         expect_silent("R5");
      end else if (hop != 4'd1) begin
         check(nreq == 0, "R4 no bus access", 64'(nreq), 64'd0);
         check(fframes == 1 && rframes == 0, "R4 forward count", 64'(fframes), 64'd1);
         check(fcnt == 11, "R8 forward length", 64'(fcnt), 64'd11);
         e[0] = {hdr[7:4], hop - 4'd1};
         for (int i = 1; i < 10; i++) e[i] = fr[i];
         for (int i = 0; i < 10; i++) s = s + e[i];
         e[10] = 8'd0 - s;
         for (int i = 0; i < 11; i++)
            check(fcap[i] == e[i], "R4 forward byte", 64'(fcap[i]), 64'(e[i]));
      end else begin
         check(nreq == 1 && fframes == 0, "R3 one local access", 64'(nreq), 64'd1);
         check(c_addr == a, "R3 address", 64'(c_addr), 64'(a));
         check(c_we == hdr[4], "R2 R3 write enable", 64'(c_we), 64'(hdr[4]));
         if (hdr[4]) check(c_wdata == d, "R3 write data", 64'(c_wdata), 64'(d));
         if (hdr[5]) begin
            check(rframes == 0, "R7 posted no reply", 64'(rframes), 64'd0);
         end else begin
            check(rframes == 1 && rcnt == 11, "R6 reply frame", 64'(rcnt), 64'd11);
            rd = hdr[4] ? d : mdl_rdata(a);
            e[0] = hdr;
            for (int i = 0; i < 4; i++) e[1+i] = a[8*(3-i) +: 8];
            for (int i = 0; i < 4; i++) e[5+i] = rd[8*(3-i) +: 8];
            e[9] = mdl_err(a) ? 8'h01 : 8'h00;
            for (int i = 0; i < 10; i++) s = s + e[i];
            e[10] = 8'd0 - s;
            for (int i = 0; i < 11; i++)
               check(rcap[i] == e[i], "R6 reply byte", 64'(rcap[i]), 64'(e[i]));
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!bus_req && !fwd_sof && !fwd_vld && !fwd_eof && fwd_byte == 8'd0, "R11 reset fwd",
            64'({bus_req, fwd_sof, fwd_vld, fwd_eof, fwd_byte}), 64'd0);
      check(!rsp_sof && !rsp_vld && !rsp_eof && rsp_byte == 8'd0, "R11 reset rsp",
            64'({rsp_sof, rsp_vld, rsp_eof, rsp_byte}), 64'd0);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;

      // Sweep hop count, write/posted flags and reserved bits
      for (int hop = 0; hop < 16; hop++) begin
         for (int f = 0; f < 8; f++) begin
            logic [7:0]  h = {{2{f[2]}}, f[1], f[0], 4'(hop)};
            logic [31:0] a = 32'hA000_0000 | (32'(hop) << 16) | (32'(f) << 8)
                             | (f[2] ? 32'hF : 32'h3);
            logic [31:0] d = 32'hC0DE_0000 ^ {24'd0, 4'(hop), 4'(f)};
            run_case(h, a, d, 1 + (hop + f) % 3);
         end
      end

      // R1: bad checksum, local read
      clear_caps(); build(8'h01, 32'h1234_5670, 32'h0, 8'h00); fr[10] = fr[10] + 8'd1;
      send(11); repeat (40) @(posedge clk); #1;
      expect_silent("R1 bad sum");
      // R1: bad checksum, forwarded frame
      clear_caps(); build(8'h03, 32'h1234_5670, 32'h0, 8'h00); fr[10] = fr[10] ^ 8'h80;
      send(11); repeat (40) @(posedge clk); #1;
      expect_silent("R1 bad sum fwd");
      // R1: ten bytes summing to zero
      clear_caps(); build(8'h02, 32'h0000_0011, 32'h0, 8'h00); fr[9] = fr[10];
      send(10); repeat (40) @(posedge clk); #1;
      expect_silent("R1 short");
      // R1: twelve bytes summing to zero
      clear_caps(); build(8'h01, 32'h0000_0022, 32'h0, 8'h00); fr[11] = 8'h00;
      send(12); repeat (40) @(posedge clk); #1;
      expect_silent("R1 long");

      // R9: a second frame during a slow local read is discarded
      clear_caps(); bus_lat = 8;
      build(8'h01, 32'h0000_4444, 32'h0, 8'h00);
      send(11);
      build(8'h02, 32'h0000_5555, 32'h0, 8'h00);
      send(11);
      repeat (60) @(posedge clk); #1;
      check(nreq == 1, "R9 single access", 64'(nreq), 64'd1);
      check(fframes == 0, "R9 busy frame discarded", 64'(fframes), 64'd0);
      check(rframes == 1 && rcap[8] == mdl_rdata(32'h0000_4444)[7:0], "R9 first reply intact",
            64'(rcap[8]), 64'(mdl_rdata(32'h0000_4444)[7:0]));
      // Normal service after the discard
      run_case(8'h04, 32'h0000_6666, 32'h7777_8888, 2);

      finish_run();
   end
endmodule